// File: doc/BRIEF.md
# Event Readout Frame Builder

This block turns the zero-suppressed hit words of one triggered event into a self-describing readout frame. A one-cycle start strobe opens an event. Hit words then arrive on a valid/ready stream, and the word flagged as last closes the event. The payload is held in a local store until the whole event is in. This means the frame header can state the exact payload length before any payload word leaves the block.

The outgoing frame has a header and a trailer around the stored payload. The header gives a start marker, a build version, the card's running trigger number and the payload length. The trailer gives a checksum and a fixed closing word. From these fields a host can spot corruption, find the next frame boundary after damaged data, and re-pair events from several cards even when the cards were read out in different orders. The output is a valid/ready stream that may be stalled for any length of time.

Top module: `event_frame_builder`

## Requirements
- R1: A frame leaves in this order: marker word (parameter MARKER), version word, trigger word, length word, the payload words, checksum word, closing word (parameter END_WORD). outValid is high for exactly those words and low otherwise, and the first word after outValid rises is the marker.
- R2: The version word equals the VERSION parameter.
- R3: The trigger word holds the frame's trigger number, zero-extended from TRIG_W bits. It is 0 for the first frame after reset and rises by one after each frame's closing word is accepted, wrapping from 2^TRIG_W-1 to 0.
- R4: In the length word, bits DATA_W-2..0 hold the number of payload words in the frame. The top bit (DATA_W-1) is the overflow flag, and it is 0 when the event fits in the store.
- R5: Payload words leave in the order they arrived.
- R6: When an event brings more than BUF_DEPTH words, the first BUF_DEPTH words are kept and the rest are accepted and dropped. The length word then reads BUF_DEPTH with its overflow bit set.
- R7: The checksum word is CRC-16 with polynomial 0x1021, start value 0xFFFF and data taken MSB first. It runs over every word from the marker to the last payload word and restarts for each frame.
- R8: While outValid is high and outReady is low, outData holds its value and no word is lost or repeated.
- R9: inReady is high only between an accepted start strobe and the accepted last word. Input words and start strobes that arrive at any other time have no effect.
- R10: Directly after reset, outValid and inReady are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| evtStart | input | 1 | One-cycle strobe that opens an event |
| inValid | input | 1 | Input hit word valid |
| inReady | output | 1 | Block accepts input hit words |
| inData | input | DATA_W | Hit word |
| inLast | input | 1 | Marks the final hit word of the event |
| outValid | output | 1 | Output frame word valid |
| outReady | input | 1 | Downstream accepts the output word |
| outData | output | DATA_W | Output frame word |

## Verification
The hardest case to reach is a stall on the output that lands on every field of the frame. This matters most at the switch from the length word to the payload and from the last payload word to the checksum, in frames that overflowed or that exactly fill the store. The bench gets there by varying outReady with a pseudo-random sequence and with a strict alternating pattern. It also feeds events of one word, exactly BUF_DEPTH words, and BUF_DEPTH plus a few words. The trigger number is only checked across its wrap because the bench builds the block with a narrow trigger field and sends more frames than that field can count.

// File: rtl/frame_build_pkg.sv
package frame_build_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_CAPT, S_MARK, S_VER, S_TRIG, S_CNT, S_PAY, S_CRC, S_END
  } fbState_e;

  typedef enum logic [2:0] {
    SEL_MARK, SEL_VER, SEL_TRIG, SEL_CNT, SEL_PAY, SEL_CRC, SEL_END
  } fieldSel_e;

  typedef struct packed {
    logic      clear;
    logic      capture;
    logic      crcEn;
    logic      rdNext;
    logic      bumpTrig;
    fieldSel_e sel;
  } fbStrobe_t;

endpackage

// File: rtl/frame_build_ctrl.sv
module frame_build_ctrl
  import frame_build_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      evtStart,
  input  logic      inValid,
  input  logic      inLast,
  input  logic      outReady,
  input  logic      lastRd,
  input  logic      bufEmpty,
  output logic      inReady,
  output logic      outValid,
  output fbStrobe_t stb
);

  fbState_e state, nxtState;
  logic     emit;

  always_comb begin
    outValid = (state != S_IDLE) && (state != S_CAPT);
    inReady  = (state == S_CAPT);
    emit     = outValid && outReady;

    stb          = '0;
    stb.clear    = (state == S_IDLE) && evtStart;
    stb.capture  = (state == S_CAPT) && inValid;
    stb.crcEn    = emit && (state != S_CRC) && (state != S_END);
    stb.rdNext   = emit && (state == S_PAY);
    stb.bumpTrig = emit && (state == S_END);

    case (state)
      S_VER:   stb.sel = SEL_VER;
      S_TRIG:  stb.sel = SEL_TRIG;
      S_CNT:   stb.sel = SEL_CNT;
      S_PAY:   stb.sel = SEL_PAY;
      S_CRC:   stb.sel = SEL_CRC;
      S_END:   stb.sel = SEL_END;
      default: stb.sel = SEL_MARK;
    endcase

    nxtState = state;
    case (state)
      S_IDLE: if (evtStart) nxtState = S_CAPT;
      S_CAPT: if (inValid && inLast) nxtState = S_MARK;
      S_MARK: if (emit) nxtState = S_VER;
      S_VER:  if (emit) nxtState = S_TRIG;
      S_TRIG: if (emit) nxtState = S_CNT;
      S_CNT:  if (emit) nxtState = bufEmpty ? S_CRC : S_PAY;
      S_PAY:  if (emit && lastRd) nxtState = S_CRC;
      S_CRC:  if (emit) nxtState = S_END;
      S_END:  if (emit) nxtState = S_IDLE;
      default: nxtState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nxtState;
  end

  // R9: capture is only ever entered from idle
  p_start_only_idle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE && state != S_CAPT) |=> (state != S_CAPT));

  // R1: an event always ends its capture with a marker word
  p_capture_exit_r1: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && inValid && inLast) |=> (outValid && stb.sel == SEL_MARK));

endmodule

// File: rtl/frame_build_datapath.sv
module frame_build_datapath
  import frame_build_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                BUF_DEPTH = 32,
  parameter int                TRIG_W    = 16,
  parameter logic [DATA_W-1:0] VERSION   = 'h0107,
  parameter logic [DATA_W-1:0] MARKER    = 'hA5C3,
  parameter logic [DATA_W-1:0] END_WORD  = 'h5AE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fbStrobe_t         stb,
  input  logic [DATA_W-1:0] inData,
  output logic [DATA_W-1:0] outData,
  output logic              lastRd,
  output logic              bufEmpty
);

  localparam int CNT_W = $clog2(BUF_DEPTH + 1);
  localparam int IDX_W = $clog2(BUF_DEPTH);

  logic [DATA_W-1:0] store [BUF_DEPTH];
  logic [CNT_W-1:0]  wrCnt;
  logic [IDX_W-1:0]  rdIdx;
  logic              ovf;
  logic [TRIG_W-1:0] trigCnt;
  logic [15:0]       crcReg;
  logic [CNT_W-1:0]  rdPlus;

  function automatic logic [15:0] crcStep(logic [15:0] c, logic [DATA_W-1:0] w);
    logic [15:0] x;
    logic        fb;
    x = c;
    for (int i = DATA_W - 1; i >= 0; i--) begin
      fb = x[15] ^ w[i];
      x  = {x[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    end
    return x;
  endfunction

  always_ff @(posedge clk) begin
    if (stb.capture && (wrCnt != CNT_W'(BUF_DEPTH)))
      store[IDX_W'(wrCnt)] <= inData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrCnt   <= '0;
      ovf     <= 1'b0;
      rdIdx   <= '0;
      crcReg  <= 16'hFFFF;
      trigCnt <= '0;
    end else begin
      if (stb.clear) begin
        wrCnt  <= '0;
        ovf    <= 1'b0;
        rdIdx  <= '0;
        crcReg <= 16'hFFFF;
      end else begin
        if (stb.capture) begin
          if (wrCnt != CNT_W'(BUF_DEPTH)) wrCnt <= wrCnt + 1'b1;
          else                            ovf   <= 1'b1;
        end
        if (stb.rdNext) rdIdx  <= rdIdx + 1'b1;
        if (stb.crcEn)  crcReg <= crcStep(crcReg, outData);
      end
      if (stb.bumpTrig) trigCnt <= trigCnt + 1'b1;
    end
  end

  always_comb begin
    rdPlus   = CNT_W'(rdIdx) + CNT_W'(1);
    lastRd   = (rdPlus == wrCnt);
    bufEmpty = (wrCnt == '0);
    case (stb.sel)
      SEL_VER:  outData = VERSION;
      SEL_TRIG: outData = DATA_W'(trigCnt);
      SEL_CNT:  outData = {ovf, (DATA_W-1)'(wrCnt)};
      SEL_PAY:  outData = store[rdIdx];
      SEL_CRC:  outData = DATA_W'(crcReg);
      SEL_END:  outData = END_WORD;
      default:  outData = MARKER;
    endcase
  end

  // R6: the stored count never passes the store size
  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrCnt <= CNT_W'(BUF_DEPTH));

  // R6: overflow is only flagged once the store is full
  p_ovf_full_r6: assert property (@(posedge clk) disable iff (!rstN)
    ovf |-> (wrCnt == CNT_W'(BUF_DEPTH)));

  // R3: the trigger number only ever steps by one
  p_trig_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(trigCnt) |-> (trigCnt == TRIG_W'($past(trigCnt) + 1'b1)));

  // R7: the checksum restarts for every new event
  p_crc_fresh_r7: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.clear) |-> (crcReg == 16'hFFFF));

endmodule

// File: rtl/event_frame_builder.sv
module event_frame_builder
  import frame_build_pkg::*;
#(
  parameter int                DATA_W    = 16,
  parameter int                BUF_DEPTH = 32,
  parameter int                TRIG_W    = 16,
  parameter logic [DATA_W-1:0] VERSION   = 'h0107,
  parameter logic [DATA_W-1:0] MARKER    = 'hA5C3,
  parameter logic [DATA_W-1:0] END_WORD  = 'h5AE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evtStart,
  input  logic              inValid,
  output logic              inReady,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic              outValid,
  input  logic              outReady,
  output logic [DATA_W-1:0] outData
);

  fbStrobe_t stb;
  logic      lastRd;
  logic      bufEmpty;

  frame_build_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .evtStart (evtStart),
    .inValid  (inValid),
    .inLast   (inLast),
    .outReady (outReady),
    .lastRd   (lastRd),
    .bufEmpty (bufEmpty),
    .inReady  (inReady),
    .outValid (outValid),
    .stb      (stb)
  );

  frame_build_datapath #(
    .DATA_W    (DATA_W),
    .BUF_DEPTH (BUF_DEPTH),
    .TRIG_W    (TRIG_W),
    .VERSION   (VERSION),
    .MARKER    (MARKER),
    .END_WORD  (END_WORD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .stb      (stb),
    .inData   (inData),
    .outData  (outData),
    .lastRd   (lastRd),
    .bufEmpty (bufEmpty)
  );

  // R8: a stalled word is held unchanged
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady) |=> (outValid && outData == $past(outData)));

  // R1: every frame opens with the marker word
  p_marker_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(outValid) |-> (outData == MARKER));

endmodule

// File: tb/sim_event_frame_builder.sv
module sim_event_frame_builder;

  localparam int          DW    = 16;
  localparam int          DEPTH = 8;
  localparam int          TW    = 3;
  localparam logic [15:0] VER   = 16'h0107;
  localparam logic [15:0] MARK  = 16'hA5C3;
  localparam logic [15:0] ENDW  = 16'h5AE1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          evtStart = 1'b0;
  logic          inValid = 1'b0;
  logic          inReady;
  logic [DW-1:0] inData = '0;
  logic          inLast = 1'b0;
  logic          outValid;
  logic          outReady = 1'b0;
  logic [DW-1:0] outData;

  event_frame_builder #(
    .DATA_W(DW), .BUF_DEPTH(DEPTH), .TRIG_W(TW),
    .VERSION(VER), .MARKER(MARK), .END_WORD(ENDW)
  ) u0 (
    .clk(clk), .rstN(rstN), .evtStart(evtStart), .inValid(inValid),
    .inReady(inReady), .inData(inData), .inLast(inLast),
    .outValid(outValid), .outReady(outReady), .outData(outData)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference model state: 0 idle, 1 capturing, 2 emitting
  int          mState = 0;
  logic [15:0] expQ[$];
  string       tagQ[$];
  logic [15:0] payQ[$];
  bit          ovfM = 0;
  int          trigM = 0;
  bit          stallPrev = 0;
  logic [15:0] heldData = '0;
  logic [15:0] lf = 16'hACE1;

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000 && !done) begin
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", cyc, 60000);
      finishRun();
    end
  end

  task automatic check(bit ok, string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] refCrc(logic [15:0] c, logic [15:0] w);
    logic [15:0] x = c;
    for (int i = 15; i >= 0; i--) begin
      if (x[15] ^ w[i]) x = {x[14:0], 1'b0} ^ 16'h1021;
      else              x = {x[14:0], 1'b0};
    end
    return x;
  endfunction

  task automatic pushExp(logic [15:0] w, string tag);
    expQ.push_back(w);
    tagQ.push_back(tag);
  endtask

  task automatic buildFrame();
    logic [15:0] c = 16'hFFFF;
    logic [15:0] cntWord;
    cntWord = {ovfM, 15'(payQ.size())};
    pushExp(MARK, "R1");
    pushExp(VER, "R2");
    pushExp(16'(trigM), "R3");
    pushExp(cntWord, ovfM ? "R6" : "R4");
    foreach (payQ[i]) pushExp(payQ[i], "R5");
    foreach (expQ[i]) c = refCrc(c, expQ[i]);
    pushExp(c, "R7");
    pushExp(ENDW, "R1");
  endtask

  function automatic logic nextBit();
    lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
    return lf[0];
  endfunction

  // one cycle: compare at the falling edge, advance the model, drive inputs
  task automatic step(logic s, logic v, logic [15:0] d, logic l, logic r);
    int prevState;
    @(negedge clk);
    check(inReady === (mState == 1), "R9", 16'(inReady), 16'(mState == 1));
    check(outValid === (mState == 2), "R1", 16'(outValid), 16'(mState == 2));
    if (mState == 2) begin
      check(outData === expQ[0], tagQ[0], outData, expQ[0]);
      if (stallPrev) check(outData === heldData, "R8", outData, heldData);
    end
    prevState = mState;
    case (mState)
      0: if (s) begin
           mState = 1;
           payQ.delete();
           ovfM = 0;
         end
      1: if (v) begin
           if (payQ.size() < DEPTH) payQ.push_back(d);
           else                     ovfM = 1;
           if (l) begin
             buildFrame();
             mState = 2;
           end
         end
      default: if (r) begin
           void'(expQ.pop_front());
           void'(tagQ.pop_front());
           if (expQ.size() == 0) begin
             mState = 0;
             trigM = (trigM + 1) % (1 << TW);
           end
         end
    endcase
    stallPrev = (prevState == 2) && !r;
    heldData  = outData;
    evtStart = s;
    inValid  = v;
    inData   = d;
    inLast   = l;
    outReady = r;
  endtask

  function automatic logic readyFor(int mode);
    logic b;
    b = nextBit();
    if (mode == 0) return 1'b1;
    if (mode == 2) return cyc[0];
    return b;
  endfunction

  task automatic runFrame(int n, int mode);
    int guard = 0;
    step(1'b1, 1'b0, 16'h0, 1'b0, readyFor(mode));
    for (int i = 0; i < n; i++) begin
      if (mode == 1 && nextBit()) step(1'b0, 1'b0, lf, 1'b1, 1'b0);
      step(1'b0, 1'b1, lf ^ 16'(i), (i == n - 1), readyFor(mode));
    end
    while (mState != 0 && guard < 400) begin
      // R9: stray start strobes and input words while the frame drains
      step(mode == 1 ? nextBit() : 1'b0, 1'b1, lf, 1'b1, readyFor(mode));
      guard++;
    end
  endtask

  initial begin
    // R10: reset state
    repeat (3) begin
      @(negedge clk);
      check(outValid === 1'b0, "R10", 16'(outValid), 16'h0);
      check(inReady === 1'b0, "R10", 16'(inReady), 16'h0);
    end
    rstN = 1'b1;
    // R9: input while idle is ignored
    step(1'b0, 1'b1, 16'hDEAD, 1'b1, 1'b1);
    step(1'b0, 1'b1, 16'hBEEF, 1'b0, 1'b1);
    runFrame(3, 0);
    runFrame(1, 0);
    runFrame(DEPTH, 1);       // exactly full store
    runFrame(DEPTH + 3, 1);   // R6 overflow
    runFrame(DEPTH + 1, 2);   // R6 overflow by one, alternating stalls
    runFrame(2, 2);
    for (int k = 0; k < 6; k++) runFrame(1 + (k % 5), 1);  // R3 wrap
    runFrame(DEPTH - 1, 2);
    repeat (4) step(1'b0, 1'b0, 16'h0, 1'b0, 1'b1);
    done = 1;
    finishRun();
  end

endmodule